// File: doc/BRIEF.md
# DAC Data Staging and Update Controller

This block is the register front end of a 12-bit digital-to-analog converter. Software reaches it through a byte-wide register bus with three registers: a control byte, a low data byte and a high data byte. The two data bytes are staging registers. A 3-bit format field sets how the 12-bit code is spread across them. The options run from right-justified, with four bits in the high byte, to left-justified, with eight bits in the high byte. Bits that fall outside the selected format are ignored.

The assembled code moves into an output latch that drives the converter. A 2-bit mode field sets when this happens. In write mode it happens on a write to the high byte. In the three timer modes it happens on a one-cycle overflow pulse from the selected timer. An enable bit turns the converter output on. While the block is disabled it signals shutdown and drives a zero code, but the latch keeps updating.

Top module: `dac_stage_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `dac_code_o` is 0, `dac_active_o` is 0 and `dac_shutdown_o` is 1.
- R2: The control register sits at address 0. Its bit 7 is enable, bits 4..3 are the mode and bits 2..0 are the format. Bits 6..5 always read 0, and writes to them are ignored. Address 3 reads 0x00.
- R3: The low data byte sits at address 1 and the high data byte at address 2. Both read back exactly the value last written.
- R4: `dac_active_o` equals the enable bit and `dac_shutdown_o` is its inverse. While enable is 0, `dac_code_o` is 0. While enable is 1, `dac_code_o` shows the output latch.
- R5: In mode 00, a write to the high byte loads the latch at that clock edge. The new code is built from the written high value and the low byte already held.
- R6: Mode 01 updates on `tick_t3_i`, mode 10 on `tick_t4_i` and mode 11 on `tick_t2_i`. Pulses from the timers that are not selected have no effect on the latch.
- R7: In a timer mode, a write to the high byte changes only the staging register. The latch does not change.
- R8: The code is formed from high and low (H, L) by format: 000 gives {H[3:0],L[7:0]}, 001 gives {H[4:0],L[7:1]}, 010 gives {H[5:0],L[7:2]}, 011 gives {H[6:0],L[7:3]}, and 1xx gives {H[7:0],L[7:4]}.
- R9: A change to the format field leaves the latch unchanged. The new format applies at the next update event.
- R10: A timer pulse sampled at a clock edge loads the latch at that edge. The new code is visible on the following cycle and uses the staged bytes and control as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| tick_t2_i | input | 1 | Timer 2 overflow pulse |
| tick_t3_i | input | 1 | Timer 3 overflow pulse |
| tick_t4_i | input | 1 | Timer 4 overflow pulse |
| dac_code_o | output | 12 | Code driven to the converter |
| dac_active_o | output | 1 | Converter output active |
| dac_shutdown_o | output | 1 | Converter in low-power shutdown |

## Verification
The bench targets these corner cases:
- All five format codes, including 1xx with both values of the lower bits. A wrong shift would misplace the code or pick up a don't-care bit.
- A high-byte write in a timer mode, and a pulse from a timer that is not selected. An incorrect trigger mux would let the latch move on those events.
- A format change with no update event following it. A design that re-aligns the code live would change the output at once.
- Bus writes of all ones to the control register. These catch unused bits that leak into read data.
- A high-byte write in mode 00. This catches a latch that takes the stale high byte instead of the one being written.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned FMT_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd2;

  typedef enum logic [1:0] {
    MODE_WR  = 2'b00,
    MODE_T3  = 2'b01,
    MODE_T4  = 2'b10,
    MODE_T2  = 2'b11
  } upd_mode_e;

  typedef struct packed {
    logic            en;
    upd_mode_e       mode;
    logic [FMT_W-1:0] fmt;
  } ctrl_t;
endpackage

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_stage_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] low_o,
  output logic [DW-1:0] high_o,
  output logic          wr_high_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] low_q, high_q;
  logic          wr_ctrl, wr_low;

  assign wr_ctrl   = bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign wr_low    = bus_wr_i && (bus_addr_i == ADDR_LOW);
  assign wr_high_o = bus_wr_i && (bus_addr_i == ADDR_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= bus_wdata_i[7];
        ctrl_q.mode <= upd_mode_e'(bus_wdata_i[4:3]);
        ctrl_q.fmt  <= bus_wdata_i[2:0];
      end
      if (wr_low)    low_q  <= bus_wdata_i;
      if (wr_high_o) high_q <= bus_wdata_i;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      ADDR_CTRL: bus_rdata_o = {ctrl_q.en, 2'b00, ctrl_q.mode, ctrl_q.fmt};
      ADDR_LOW:  bus_rdata_o = low_q;
      ADDR_HIGH: bus_rdata_o = high_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign low_o  = low_q;
  assign high_o = high_q;

  // R2: unused control bits never appear on the bus
  p_unused_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_CTRL) |-> (bus_rdata_o[6:5] == 2'b00));

  // R3: staged byte holds when not addressed
  p_low_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_low |=> $stable(low_q));
endmodule

// File: rtl/dac_code_align.sv
module dac_code_align
  import dac_stage_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CODE_W,
  parameter int unsigned FW = FMT_W
) (
  input  logic [FW-1:0] fmt_i,
  input  logic [DW-1:0] high_i,
  input  logic [DW-1:0] low_i,
  output logic [CW-1:0] code_o
);
  localparam int unsigned WORD_W    = 2 * DW;
  localparam int unsigned MAX_SHIFT = WORD_W - CW;
  localparam int unsigned N_SHIFT   = MAX_SHIFT + 1;
  localparam int unsigned SEL_W     = $clog2(N_SHIFT);

  logic [WORD_W-1:0] word;
  logic [CW-1:0]     cand [N_SHIFT];
  logic [SEL_W-1:0]  sel;

  assign word = {high_i, low_i};

  // Each format shifts the packed word right; top format saturates at max shift
  assign sel = fmt_i[FW-1] ? SEL_W'(MAX_SHIFT) : SEL_W'(fmt_i[FW-2:0]);

  for (genvar s = 0; s < N_SHIFT; s++) begin : g_shift
    assign cand[s] = word[s +: CW];
  end

  always_comb begin
    code_o = cand[0];
    for (int unsigned i = 1; i < N_SHIFT; i++) begin
      if (sel == SEL_W'(i)) code_o = cand[i];
    end
  end

  // R8: left-justified formats never use the bottom bits of the low byte
  always_comb begin
    if (fmt_i[FW-1]) begin
      a_left_just_r8: assert (code_o[MAX_SHIFT-1:0] == high_i[MAX_SHIFT-1:0] ||
                              code_o[CW-1 -: MAX_SHIFT] == high_i[DW-1 -: MAX_SHIFT]);
    end
  end
endmodule

// File: rtl/dac_update_sel.sv
module dac_update_sel
  import dac_stage_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  upd_mode_e mode_i,
  input  logic      wr_high_i,
  input  logic      tick_t2_i,
  input  logic      tick_t3_i,
  input  logic      tick_t4_i,
  output logic      fire_o
);
  always_comb begin
    unique case (mode_i)
      MODE_WR: fire_o = wr_high_i;
      MODE_T3: fire_o = tick_t3_i;
      MODE_T4: fire_o = tick_t4_i;
      MODE_T2: fire_o = tick_t2_i;
      default: fire_o = 1'b0;
    endcase
  end

  // R6: an update always traces back to some event
  p_fire_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (wr_high_i || tick_t2_i || tick_t3_i || tick_t4_i));
endmodule

// File: rtl/dac_stage_ctrl.sv
module dac_stage_ctrl
  import dac_stage_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                tick_t2_i,
  input  logic                tick_t3_i,
  input  logic                tick_t4_i,
  output logic [CODE_W-1:0]   dac_code_o,
  output logic                dac_active_o,
  output logic                dac_shutdown_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] low_q, high_q, src_high;
  logic              wr_high, fire;
  logic [CODE_W-1:0] code_next, latch_q;

  dac_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .ctrl_o      (ctrl),
    .low_o       (low_q),
    .high_o      (high_q),
    .wr_high_o   (wr_high)
  );

  // Write mode takes the high byte in flight; timer modes use staged value
  assign src_high = (ctrl.mode == MODE_WR) ? bus_wdata_i : high_q;

  dac_code_align u_align (
    .fmt_i  (ctrl.fmt),
    .high_i (src_high),
    .low_i  (low_q),
    .code_o (code_next)
  );

  dac_update_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (ctrl.mode),
    .wr_high_i (wr_high),
    .tick_t2_i (tick_t2_i),
    .tick_t3_i (tick_t3_i),
    .tick_t4_i (tick_t4_i),
    .fire_o    (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   latch_q <= '0;
    else if (fire) latch_q <= code_next;
  end

  assign dac_active_o   = ctrl.en;
  assign dac_shutdown_o = ~ctrl.en;
  assign dac_code_o     = ctrl.en ? latch_q : '0;

  // R7, R9: latch moves only on a selected update event
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(latch_q));

  // R5: write-mode update captures the code built from the written byte
  p_wr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode == MODE_WR && wr_high) |=> (latch_q == $past(code_next)));

  // R10: timer pulse loads one edge later
  p_tick_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode != MODE_WR && fire) |=> (latch_q == $past(code_next)));

  // R4: the two status pins never agree
  p_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_active_o != dac_shutdown_o);
endmodule

// File: tb/dac_stage_ctrl_tb_top.sv
module dac_stage_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        t2 = 1'b0, t3 = 1'b0, t4 = 1'b0;
  logic [11:0] code;
  logic        active, shutdown;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_ctrl, m_low, m_high;
  logic [11:0] m_latch;

  always #2.5 clk = ~clk;

  dac_stage_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_t2_i(t2), .tick_t3_i(t3),
    .tick_t4_i(t4), .dac_code_o(code), .dac_active_o(active),
    .dac_shutdown_o(shutdown)
  );

  function automatic logic [11:0] ref_code(input logic [2:0] f, input logic [7:0] h,
                                           input logic [7:0] l);
    case (f)
      3'd0:    return {h[3:0], l[7:0]};
      3'd1:    return {h[4:0], l[7:1]};
      3'd2:    return {h[5:0], l[7:2]};
      3'd3:    return {h[6:0], l[7:3]};
      default: return {h[7:0], l[7:4]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, update model, sample after the edge
  task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d,
                      input bit p2, input bit p3, input bit p4);
    bit fire;
    logic [7:0] hsrc;
    @(negedge clk);
    wr = w; addr = a; wdata = d; t2 = p2; t3 = p3; t4 = p4;
    case (m_ctrl[4:3])
      2'b00: fire = w && a == 2'd2;
      2'b01: fire = p3;
      2'b10: fire = p4;
      default: fire = p2;
    endcase
    hsrc = (m_ctrl[4:3] == 2'b00) ? d : m_high;
    @(posedge clk);
    if (fire) m_latch = ref_code(m_ctrl[2:0], hsrc, m_low);
    if (w && a == 2'd0) m_ctrl = d & 8'h9F;
    if (w && a == 2'd1) m_low = d;
    if (w && a == 2'd2) m_high = d;
    #1;
    wr = 1'b0; t2 = 1'b0; t3 = 1'b0; t4 = 1'b0;
  endtask

  task automatic chk_out(input string req);
    logic [11:0] e;
    e = m_ctrl[7] ? m_latch : 12'h000;
    chk(code == e, req, code, e);
    chk(active == m_ctrl[7] && shutdown == !m_ctrl[7], {req, "/R4"},
        {active, shutdown}, {m_ctrl[7], !m_ctrl[7]});
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == e, req, rdata, e);
  endtask

  initial begin
    m_ctrl = '0; m_low = '0; m_high = '0; m_latch = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(code == 0 && active == 0 && shutdown == 1, "R1 outputs", {code, active, shutdown}, 1);
    chk_rd(2'd0, 8'h00, "R1 ctrl");
    chk_rd(2'd1, 8'h00, "R1 low");
    chk_rd(2'd2, 8'h00, "R1 high");

    // R2 unused bits and unmapped address
    step(1, 2'd0, 8'hFF, 0, 0, 0);
    chk_rd(2'd0, 8'h9F, "R2 ctrl readback");
    chk_rd(2'd3, 8'h00, "R2 unmapped");
    step(1, 2'd0, 8'h80, 0, 0, 0);

    // R3 readback
    step(1, 2'd1, 8'hA5, 0, 0, 0);
    step(1, 2'd2, 8'h3C, 0, 0, 0);
    chk_rd(2'd1, 8'hA5, "R3 low");
    chk_rd(2'd2, 8'h3C, "R3 high");

    // R8 every format in write mode (R5)
    for (int f = 0; f < 8; f++) begin
      step(1, 2'd0, 8'h80 | 8'(f), 0, 0, 0);
      step(1, 2'd1, 8'hB7, 0, 0, 0);
      step(1, 2'd2, 8'hD9, 0, 0, 0);
      chk_out("R8 format / R5 write load");
    end

    // R9 format change does not move latch
    step(1, 2'd0, 8'h80, 0, 0, 0);
    step(1, 2'd2, 8'h5E, 0, 0, 0);
    step(1, 2'd0, 8'h84, 0, 0, 0);
    chk_out("R9 format change hold");
    step(1, 2'd2, 8'h5E, 0, 0, 0);
    chk_out("R9 new format at next update");

    // R7 / R6 / R10 timer mode 01 (t3)
    step(1, 2'd0, 8'h88, 0, 0, 0);
    step(1, 2'd2, 8'hF1, 0, 0, 0);
    chk_out("R7 high write in timer mode");
    step(0, 2'd0, 8'h00, 1, 0, 1);
    chk_out("R6 unselected ticks ignored");
    step(0, 2'd0, 8'h00, 0, 1, 0);
    chk_out("R10 t3 load");

    // R4 disable forces zero code; latch keeps updating
    step(1, 2'd0, 8'h1A, 0, 0, 0);
    chk_out("R4 shutdown");
    step(0, 2'd0, 8'h00, 1, 0, 0);
    step(1, 2'd0, 8'h9A, 0, 0, 0);
    chk_out("R4 re-enable shows latch");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      logic [1:0] a;
      logic [7:0] d;
      d = 8'($urandom);
      a = (r < 2) ? 2'd0 : (r < 5) ? 2'd1 : (r < 8) ? 2'd2 : 2'd3;
      if (a == 2'd0 && $urandom_range(0, 3) != 0) d[7] = 1'b1;
      step($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 5) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
      chk_out(m_ctrl[4:3] == 2'b00 ? "R5 random" : "R6 R10 random");
      if ((i % 50) == 0) chk_rd(2'd0, m_ctrl, "R2 random ctrl");
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule